// File: doc/BRIEF.md
# Single-Accumulator Instruction Processor

This block is a small multicycle processor with one accumulator and a one-address instruction format. Each 16-bit instruction word has a 4-bit operation code and a 12-bit memory address. Arithmetic operations always use the accumulator as their implicit first operand and destination. A zero flag holds the outcome of the last accumulator update, and a branch-if-zero instruction tests that flag.

The processor uses one synchronous, word-addressed memory port for both instructions and data. The memory returns read data one clock after the address is presented. Each instruction passes through a fetch state, a decode state, an optional operand-read state and an execute state. A halt instruction stops the sequence. The halted output then stays high until reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `halted` is low, `mem_we` is low and `mem_addr` equals `START_ADDR` (default 0x100). Reset clears the accumulator and the zero flag.
- R2: Bits [15:12] of an instruction are its operation code and bits [11:0] its operand address. Code 0010 loads the accumulator from the addressed word.
- R3: Code 0001 adds the addressed word to the accumulator, modulo 2^16.
- R4: Code 0100 subtracts the addressed word from the accumulator, modulo 2^16.
- R5: Code 0011 writes the accumulator to the addressed word. `mem_we` is a single-cycle strobe and is never high in two consecutive cycles.
- R6: Code 0101 jumps to its address when the zero flag is set. Otherwise execution continues at the next sequential address.
- R7: Code 0110 always jumps to its address, backward or forward.
- R8: Only load, add and subtract update the zero flag, which is set when their result is 0. Store, branch and unused codes leave the flag unchanged.
- R9: Code 0000 raises `halted`, which stays high until reset. While halted there are no further writes, `mem_addr` holds steady, and instructions placed after the halt never execute.
- R10: Codes 0111 to 1111 do nothing except advance to the next sequential address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Registered memory word address |
| mem_wdata | output | 16 | Registered store data |
| mem_we | output | 1 | Registered write strobe |
| mem_rdata | input | 16 | Memory read data, valid one cycle after address |
| halted | output | 1 | High once a halt instruction has been decoded |

## Verification
The three-operand summing program is run over a table of operand sets: small values, all zeros, values that wrap past 0xFFFF, and values whose sum wraps to exactly zero. A trailing branch-if-zero then tells a correctly held zero flag apart from a flag that the store clobbered or never set. Directed programs cover several cases:
- a subtract-driven countdown loop, which takes the conditional branch once and the backward unconditional branch repeatedly;
- a branch right after reset, which separates a cleared flag from a stale one;
- a zero load followed by a nonzero load;
- an unused opcode;
- code placed after a halt.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_HALT  = 4'b0000,
    OP_ADD   = 4'b0001,
    OP_LOAD  = 4'b0010,
    OP_STORE = 4'b0011,
    OP_SUB   = 4'b0100,
    OP_BRZ   = 4'b0101,
    OP_BRA   = 4'b0110
  } op_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_READ,
    ST_EXEC,
    ST_HALT
  } state_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              upd
);
  always_comb begin
    result = acc;
    upd    = 1'b1;
    case (op)
      OP_LOAD: result = operand;
      OP_ADD:  result = acc + operand;
      OP_SUB:  result = acc - operand;
      default: upd    = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] dec_op,
  input  logic            zero_flag,
  output state_e          st,
  output logic            branch_go,
  output logic            need_read,
  output logic            is_store,
  output logic            is_halt
);
  state_e st_nxt;

  always_comb begin
    branch_go = (dec_op == OP_BRA) || ((dec_op == OP_BRZ) && zero_flag);
    need_read = (dec_op == OP_LOAD) || (dec_op == OP_ADD) || (dec_op == OP_SUB);
    is_store  = (dec_op == OP_STORE);
    is_halt   = (dec_op == OP_HALT);
  end

  always_comb begin
    st_nxt = st;
    case (st)
      ST_FETCH:  st_nxt = ST_DECODE;
      ST_DECODE: begin
        if (is_halt)        st_nxt = ST_HALT;
        else if (branch_go) st_nxt = ST_FETCH;
        else if (need_read) st_nxt = ST_READ;
        else                st_nxt = ST_EXEC;
      end
      ST_READ:   st_nxt = ST_EXEC;
      ST_EXEC:   st_nxt = ST_FETCH;
      default:   st_nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_FETCH;
    else     st <= st_nxt;
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_pkg::*;
#(
  parameter int                DATA_W     = 16,
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] START_ADDR = 12'h100
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);
  localparam int                OP_MSB  = DATA_W - 1;
  localparam logic [ADDR_W-1:0] PC_STEP = 1;

  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] ir_q;
  logic              zero_q;

  state_e            st;
  logic              branch_go, need_read, is_store, is_halt;
  logic [OP_W-1:0]   dec_op;
  logic [ADDR_W-1:0] dec_tgt;
  logic [DATA_W-1:0] alu_res;
  logic              alu_upd;

  assign dec_op  = mem_rdata[OP_MSB -: OP_W];
  assign dec_tgt = mem_rdata[ADDR_W-1:0];

  acc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .dec_op    (dec_op),
    .zero_flag (zero_q),
    .st        (st),
    .branch_go (branch_go),
    .need_read (need_read),
    .is_store  (is_store),
    .is_halt   (is_halt)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (ir_q[OP_MSB -: OP_W]),
    .acc     (acc_q),
    .operand (mem_rdata),
    .result  (alu_res),
    .upd     (alu_upd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= START_ADDR;
      mem_addr  <= START_ADDR;
      acc_q     <= '0;
      zero_q    <= 1'b0;
      ir_q      <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      halted    <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      case (st)
        ST_DECODE: begin
          ir_q <= mem_rdata;
          if (is_halt) begin
            halted <= 1'b1;
          end else if (branch_go) begin
            pc_q     <= dec_tgt;
            mem_addr <= dec_tgt;
          end else if (need_read) begin
            mem_addr <= dec_tgt;
          end else if (is_store) begin
            mem_addr  <= dec_tgt;
            mem_wdata <= acc_q;
            mem_we    <= 1'b1;
          end
        end
        ST_EXEC: begin
          if (alu_upd) begin
            acc_q  <= alu_res;
            zero_q <= (alu_res == '0);
          end
          pc_q     <= pc_q + PC_STEP;
          mem_addr <= pc_q + PC_STEP;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] START_ADDR = 12'h100
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              halted
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (mem_addr == START_ADDR && !mem_we && !halted));

  p_single_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  p_halt_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(mem_addr));
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .START_ADDR(START_ADDR)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .halted   (halted)
);

// File: tb/test_acc_cpu.sv
module test_acc_cpu;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam logic [AW-1:0] START = 12'h100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic          halted;

  logic [DW-1:0] mem [1 << AW];
  int n_chk = 0, n_fail = 0, wr_after_halt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  acc_cpu #(.DATA_W(DW), .ADDR_W(AW), .START_ADDR(START)) i_acc_cpu (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (!rst && halted && mem_we) wr_after_halt++;
  end

  // Stimulus table: three operands and their 16-bit sum
  localparam logic [63:0] VEC [5] = '{
    {16'h0002, 16'h0003, 16'h0004, 16'h0009},
    {16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {16'hFFFF, 16'h0001, 16'h0000, 16'h0000},
    {16'h8000, 16'h8000, 16'h0005, 16'h0005},
    {16'h1234, 16'h1111, 16'h0001, 16'h2346}
  };

  function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
  endtask

  task automatic run_prog(input string req);
    int cyc;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    wr_after_halt = 0;
    cyc = 0;
    while (!halted && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(halted, req, {15'd0, halted}, 16'd1);
  endtask

  initial begin
    logic [AW-1:0] a_hold;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(mem_addr == START && !halted && !mem_we, "R1 reset outputs", {4'd0, mem_addr}, {4'd0, START});

    // Table walk: R2 load, R3 add, R5 store, R8 flag from add, kept across store
    for (int v = 0; v < 5; v++) begin
      logic [DW-1:0] s;
      clear_mem();
      mem[12'h100] = ins(4'b0010, 12'h201);
      mem[12'h101] = ins(4'b0001, 12'h202);
      mem[12'h102] = ins(4'b0001, 12'h203);
      mem[12'h103] = ins(4'b0011, 12'h204);
      mem[12'h104] = ins(4'b0101, 12'h106);
      mem[12'h105] = ins(4'b0011, 12'h205);
      mem[12'h106] = ins(4'b0000, 12'h000);
      mem[12'h201] = VEC[v][63:48];
      mem[12'h202] = VEC[v][47:32];
      mem[12'h203] = VEC[v][31:16];
      mem[12'h205] = 16'hCCCC;
      s = VEC[v][15:0];
      run_prog("R9 halt reached");
      chk(mem[12'h204] == s, "R3 sum stored", mem[12'h204], s);
      chk(mem[12'h205] == ((s == 0) ? 16'hCCCC : s), "R8 zero flag after add/store",
          mem[12'h205], (s == 0) ? 16'hCCCC : s);
    end

    // R4 subtract with wrap
    clear_mem();
    mem[12'h100] = ins(4'b0010, 12'h201);
    mem[12'h101] = ins(4'b0100, 12'h202);
    mem[12'h102] = ins(4'b0011, 12'h203);
    mem[12'h103] = ins(4'b0000, 12'h000);
    mem[12'h201] = 16'd5;
    mem[12'h202] = 16'd7;
    run_prog("R4 halt reached");
    chk(mem[12'h203] == 16'hFFFE, "R4 subtract", mem[12'h203], 16'hFFFE);

    // R6/R7 countdown loop: backward branch, zero branch taken once
    clear_mem();
    mem[12'h100] = ins(4'b0010, 12'h200);
    mem[12'h101] = ins(4'b0100, 12'h201);
    mem[12'h102] = ins(4'b0011, 12'h200);
    mem[12'h103] = ins(4'b0010, 12'h202);
    mem[12'h104] = ins(4'b0001, 12'h201);
    mem[12'h105] = ins(4'b0011, 12'h202);
    mem[12'h106] = ins(4'b0010, 12'h200);
    mem[12'h107] = ins(4'b0101, 12'h109);
    mem[12'h108] = ins(4'b0110, 12'h100);
    mem[12'h109] = ins(4'b0000, 12'h000);
    mem[12'h200] = 16'd3;
    mem[12'h201] = 16'd1;
    run_prog("R7 loop halts");
    chk(mem[12'h202] == 16'd3, "R7 loop iterations", mem[12'h202], 16'd3);
    chk(mem[12'h200] == 16'd0, "R6 counter at exit", mem[12'h200], 16'd0);

    // R8: store and a taken branch keep a set zero flag
    clear_mem();
    mem[12'h100] = ins(4'b0010, 12'h220);
    mem[12'h101] = ins(4'b0011, 12'h210);
    mem[12'h102] = ins(4'b0101, 12'h104);
    mem[12'h103] = ins(4'b0011, 12'h211);
    mem[12'h104] = ins(4'b0101, 12'h106);
    mem[12'h105] = ins(4'b0011, 12'h212);
    mem[12'h106] = ins(4'b0000, 12'h000);
    mem[12'h210] = 16'h1111;
    mem[12'h211] = 16'hAAAA;
    mem[12'h212] = 16'hBBBB;
    run_prog("R8 halt reached");
    chk(mem[12'h210] == 16'h0000, "R5 store of zero", mem[12'h210], 16'h0000);
    chk(mem[12'h211] == 16'hAAAA, "R8 flag kept over store", mem[12'h211], 16'hAAAA);
    chk(mem[12'h212] == 16'hBBBB, "R8 flag kept over branch", mem[12'h212], 16'hBBBB);

    // R1/R6: flag clear after reset so zero branch falls through
    clear_mem();
    mem[12'h100] = ins(4'b0101, 12'h102);
    mem[12'h101] = ins(4'b0011, 12'h213);
    mem[12'h102] = ins(4'b0000, 12'h000);
    mem[12'h213] = 16'h5555;
    run_prog("R1 halt reached");
    chk(mem[12'h213] == 16'h0000, "R1 zero flag cleared", mem[12'h213], 16'h0000);

    // R8: nonzero load clears the flag
    clear_mem();
    mem[12'h100] = ins(4'b0010, 12'h220);
    mem[12'h101] = ins(4'b0010, 12'h221);
    mem[12'h102] = ins(4'b0101, 12'h104);
    mem[12'h103] = ins(4'b0011, 12'h214);
    mem[12'h104] = ins(4'b0000, 12'h000);
    mem[12'h221] = 16'd5;
    mem[12'h214] = 16'h7777;
    run_prog("R8 halt reached");
    chk(mem[12'h214] == 16'd5, "R8 load clears flag", mem[12'h214], 16'd5);

    // R10 unused opcode, then R9 halt blocks later code
    clear_mem();
    mem[12'h100] = ins(4'b0010, 12'h201);
    mem[12'h101] = ins(4'b0111, 12'h201);
    mem[12'h102] = ins(4'b1111, 12'h202);
    mem[12'h103] = ins(4'b0011, 12'h204);
    mem[12'h104] = ins(4'b0000, 12'h000);
    mem[12'h105] = ins(4'b0011, 12'h205);
    mem[12'h201] = 16'd7;
    mem[12'h205] = 16'h9999;
    run_prog("R10 halt reached");
    chk(mem[12'h204] == 16'd7, "R10 unused opcode no-op", mem[12'h204], 16'd7);
    a_hold = mem_addr;
    repeat (20) @(negedge clk);
    chk(halted, "R9 halted sticky", {15'd0, halted}, 16'd1);
    chk(mem[12'h205] == 16'h9999, "R9 no execution after halt", mem[12'h205], 16'h9999);
    chk(wr_after_halt == 0, "R9 no writes while halted", 16'(wr_after_halt), 16'd0);
    chk(mem_addr == a_hold, "R9 address held", {4'd0, mem_addr}, {4'd0, a_hold});

    // R1: reset from halted
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!halted && !mem_we && mem_addr == START, "R1 reset leaves halt", {4'd0, mem_addr}, {4'd0, START});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule